// File: doc/BRIEF.md
# Sixteen-Lane Memory Access Coalescer

This block takes one load or store request from a group of sixteen parallel lanes and turns it into as few wide memory transactions as it can. Each lane supplies an enable bit and a byte address. All lanes share one access width, given as a size code. Once a request is accepted, the block issues transactions one at a time over a valid/ready handshake. Each transaction carries an aligned base address, a length in bytes and a sixteen-bit mask of the lanes it serves. A single-cycle completion pulse follows the last transaction.

A mode bit selects one of two merging rules. The strict rule merges only when every enabled lane k addresses word k of one aligned stripe. If the pattern is out of order or misaligned, it gives up and issues one transaction per enabled lane. The relaxed rule issues one transaction per distinct aligned 128-byte segment that enabled lanes touch, in ascending address order. It shrinks each transaction to 64 or 32 bytes when the touched bytes allow.

Top module: `halfwarp_coalescer`

## Requirements
- R1: In strict mode (reqRelaxed=0), size codes 0 to 3 give word widths of 1, 2, 4 and 8 bytes, and the stripe is 16 words. If every enabled lane k addresses stripe base + k*width, and the stripe base is the first enabled lane's address rounded down to a stripe boundary, exactly one transaction is issued. Its base is the stripe base, its length is 16*width and its mask is the enabled set.
- R2: In strict mode with size code 4 (16-byte words) and a sequential, aligned pattern, two 128-byte transactions are possible. Lanes 0-7 are served at the stripe base, first. Lanes 8-15 are served at stripe base + 128. A half with no enabled lane gets no transaction.
- R3: In strict mode, disabled lanes do not affect merging, whatever their addresses are.
- R4: In strict mode, if any enabled lane breaks the sequential aligned pattern, one transaction is issued per enabled lane, in ascending lane index. Each has a one-hot mask, a base equal to the lane address rounded down to the word width, and a length equal to the word width.
- R5: In relaxed mode (reqRelaxed=1), one transaction is issued per distinct 128-byte segment touched by enabled lanes, in ascending address order, whatever order the lanes use within a segment.
- R6: In relaxed mode, a transaction is reduced to the aligned 64-byte half when all its touched bytes fall inside that half. It is reduced further to the aligned 32-byte quarter when they fall inside that quarter. One request may mix lengths.
- R7: Every transaction mask is nonzero, a subset of the enabled set, and disjoint from the earlier masks of the same request. When the completion pulse fires, the union of the masks equals the enabled set.
- R8: While txnValid is high and txnReady is low, base, length and mask hold steady. reqReady is high only when no request is in progress.
- R9: done pulses for one cycle, in the cycle after the last transaction handshake. For a request with no enabled lane, it pulses in the cycle after acceptance.
- R10: After reset, reqReady is high and txnValid and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Block idle and able to accept a request |
| reqRelaxed | input | 1 | 1 selects the relaxed rule, 0 the strict rule |
| reqSize | input | 3 | Access width code, 0..4 meaning 1,2,4,8,16 bytes |
| reqActive | input | 16 | Lane enable bits |
| reqAddr | input | 512 | Lane byte addresses, lane k at bits 32k+31:32k |
| txnValid | output | 1 | Transaction offered |
| txnReady | input | 1 | Transaction taken by memory side |
| txnBase | output | 32 | Aligned transaction base address |
| txnBytes | output | 8 | Transaction length in bytes |
| txnMask | output | 16 | Lanes served by the transaction |
| done | output | 1 | One-cycle completion pulse |

## Verification
A corrupted pending-lane register shows up at the next handshake. A lane is served twice or never, or a mask carries bits outside the enabled set, and the completion pulse comes one transaction early or late. A wrong segment minimum or offset range shows at once as a misordered base or a wrong length on the first transaction of a request. A stall-handling fault changes the outputs on the cycle right after a refused offer.

// File: rtl/coal_pkg.sv
package coal_pkg;
  typedef struct packed {
    logic load;
    logic retire;
  } ctrlStrobe_t;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } coalState_t;

  localparam logic [2:0] SIZE_WIDE = 3'd4;
endpackage

// File: rtl/coal_datapath.sv
module coal_datapath
  import coal_pkg::*;
#(
  parameter int NT     = 16,
  parameter int AW     = 32,
  parameter int SEG_LG = 7
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobe_t          ctrl,
  input  logic                 reqRelaxed,
  input  logic [2:0]           reqSize,
  input  logic [NT-1:0]        reqActive,
  input  logic [NT*AW-1:0]     reqAddr,
  output logic                 pendEmpty,
  output logic [AW-1:0]        txnBase,
  output logic [SEG_LG:0]      txnBytes,
  output logic [NT-1:0]        txnMask
);
  localparam int IDX_W     = $clog2(NT);
  localparam int HALF      = NT / 2;
  localparam int SEG_W     = AW - SEG_LG;
  localparam int SEG_BYTES = 1 << SEG_LG;

  logic [AW-1:0]     addrQ [NT];
  logic [2:0]        sizeQ;
  logic              relaxedQ;
  logic [NT-1:0]     activeQ;
  logic [NT-1:0]     pendQ;

  always_ff @(posedge clk) begin
    if (ctrl.load) begin
      for (int k = 0; k < NT; k++) addrQ[k] <= reqAddr[k*AW +: AW];
      sizeQ    <= reqSize;
      relaxedQ <= reqRelaxed;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeQ <= '0;
      pendQ   <= '0;
    end else if (ctrl.load) begin
      activeQ <= reqActive;
      pendQ   <= reqActive;
    end else if (ctrl.retire) begin
      pendQ <= pendQ & ~txnMask;
    end
  end

  assign pendEmpty = (pendQ == '0);

  function automatic logic [IDX_W-1:0] firstSet(input logic [NT-1:0] v);
    logic [IDX_W-1:0] idx;
    idx = '0;
    for (int k = NT - 1; k >= 0; k--) if (v[k]) idx = IDX_W'(k);
    return idx;
  endfunction

  logic [SEG_LG:0]   wordBytes;
  logic [AW-1:0]     wordMaskA;
  logic [AW-1:0]     stripeMaskA;
  logic [IDX_W-1:0]  leadIdx;
  logic [AW-1:0]     stripeBase;

  assign wordBytes   = {{SEG_LG{1'b0}}, 1'b1} << sizeQ;
  assign wordMaskA   = (AW'(1) << sizeQ) - AW'(1);
  assign stripeMaskA = ~((AW'(NT) << sizeQ) - AW'(1));
  assign leadIdx     = firstSet(activeQ);
  assign stripeBase  = addrQ[leadIdx] & stripeMaskA;

  logic [AW-1:0]     laneAligned [NT];
  logic [SEG_W-1:0]  laneSeg     [NT];
  logic [SEG_LG-1:0] laneLo      [NT];
  logic [SEG_LG-1:0] laneHi      [NT];
  logic [NT-1:0]     laneStrictOk;

  for (genvar k = 0; k < NT; k++) begin : gLane
    assign laneAligned[k]  = addrQ[k] & ~wordMaskA;
    assign laneSeg[k]      = laneAligned[k][AW-1:SEG_LG];
    assign laneLo[k]       = laneAligned[k][SEG_LG-1:0];
    assign laneHi[k]       = laneLo[k] + wordMaskA[SEG_LG-1:0];
    assign laneStrictOk[k] = !activeQ[k] ||
                             (addrQ[k] == stripeBase + (AW'(k) << sizeQ));
  end

  // relaxed rule: lowest touched segment, its lanes and touched byte range
  logic [SEG_W-1:0]  minSeg;
  logic [NT-1:0]     relMask;
  logic [SEG_LG-1:0] relLo, relHi;
  logic              inHalf, inQuarter;
  logic [SEG_LG:0]   relBytes;
  logic [SEG_LG-1:0] relOff;

  always_comb begin
    minSeg = '1;
    for (int k = 0; k < NT; k++)
      if (pendQ[k] && laneSeg[k] < minSeg) minSeg = laneSeg[k];
    relMask = '0;
    relLo   = '1;
    relHi   = '0;
    for (int k = 0; k < NT; k++) begin
      if (pendQ[k] && laneSeg[k] == minSeg) begin
        relMask[k] = 1'b1;
        if (laneLo[k] < relLo) relLo = laneLo[k];
        if (laneHi[k] > relHi) relHi = laneHi[k];
      end
    end
  end

  assign inHalf    = relLo[SEG_LG-1] == relHi[SEG_LG-1];
  assign inQuarter = inHalf && (relLo[SEG_LG-2] == relHi[SEG_LG-2]);
  assign relBytes  = inQuarter ? (SEG_LG+1)'(SEG_BYTES / 4) :
                     inHalf    ? (SEG_LG+1)'(SEG_BYTES / 2) :
                                 (SEG_LG+1)'(SEG_BYTES);
  assign relOff    = relLo & ~(relBytes[SEG_LG-1:0] - SEG_LG'(1));

  // strict rule
  logic              strictOk;
  logic              lowerPend;
  logic [NT-1:0]     lowerHalfMask;
  logic [IDX_W-1:0]  fallIdx;

  assign strictOk      = &laneStrictOk;
  assign lowerHalfMask = {{(NT-HALF){1'b0}}, {HALF{1'b1}}};
  assign lowerPend     = |(pendQ & lowerHalfMask);
  assign fallIdx       = firstSet(pendQ);

  always_comb begin
    txnBase  = '0;
    txnBytes = '0;
    txnMask  = '0;
    if (relaxedQ) begin
      txnBase  = {minSeg, relOff};
      txnBytes = relBytes;
      txnMask  = relMask;
    end else if (strictOk) begin
      if (sizeQ == SIZE_WIDE) begin
        txnBytes = (SEG_LG+1)'(SEG_BYTES);
        if (lowerPend) begin
          txnBase = stripeBase;
          txnMask = pendQ & lowerHalfMask;
        end else begin
          txnBase = stripeBase + AW'(SEG_BYTES);
          txnMask = pendQ & ~lowerHalfMask;
        end
      end else begin
        txnBase  = stripeBase;
        txnBytes = wordBytes << IDX_W;
        txnMask  = pendQ;
      end
    end else begin
      txnBase          = laneAligned[fallIdx];
      txnBytes         = wordBytes;
      txnMask[fallIdx] = 1'b1;
    end
  end
endmodule

// File: rtl/coal_control.sv
module coal_control
  import coal_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        txnReady,
  input  logic        pendEmpty,
  output logic        reqReady,
  output logic        txnValid,
  output logic        done,
  output ctrlStrobe_t ctrl
);
  coalState_t stateQ, stateD;

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD      = stateQ;
    reqReady    = 1'b0;
    txnValid    = 1'b0;
    done        = 1'b0;
    ctrl        = '0;
    unique case (stateQ)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          ctrl.load = 1'b1;
          stateD    = ST_BUSY;
        end
      end
      ST_BUSY: begin
        if (pendEmpty) begin
          done   = 1'b1;
          stateD = ST_IDLE;
        end else begin
          txnValid    = 1'b1;
          ctrl.retire = txnReady;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/halfwarp_coalescer.sv
module halfwarp_coalescer
  import coal_pkg::*;
#(
  parameter int NT     = 16,
  parameter int AW     = 32,
  parameter int SEG_LG = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqRelaxed,
  input  logic [2:0]        reqSize,
  input  logic [NT-1:0]     reqActive,
  input  logic [NT*AW-1:0]  reqAddr,
  output logic              txnValid,
  input  logic              txnReady,
  output logic [AW-1:0]     txnBase,
  output logic [SEG_LG:0]   txnBytes,
  output logic [NT-1:0]     txnMask,
  output logic              done
);
  ctrlStrobe_t ctrl;
  logic        pendEmpty;

  coal_control u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .txnReady (txnReady),
    .pendEmpty(pendEmpty),
    .reqReady (reqReady),
    .txnValid (txnValid),
    .done     (done),
    .ctrl     (ctrl)
  );

  coal_datapath #(.NT(NT), .AW(AW), .SEG_LG(SEG_LG)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .reqRelaxed(reqRelaxed),
    .reqSize   (reqSize),
    .reqActive (reqActive),
    .reqAddr   (reqAddr),
    .pendEmpty (pendEmpty),
    .txnBase   (txnBase),
    .txnBytes  (txnBytes),
    .txnMask   (txnMask)
  );
endmodule

// File: rtl/coal_checker.sv
module coal_checker #(
  parameter int NT     = 16,
  parameter int AW     = 32,
  parameter int SEG_LG = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              reqRelaxed,
  input logic [NT-1:0]     reqActive,
  input logic              txnValid,
  input logic              txnReady,
  input logic [AW-1:0]     txnBase,
  input logic [SEG_LG:0]   txnBytes,
  input logic [NT-1:0]     txnMask,
  input logic              done
);
  logic [NT-1:0] activeCap, coveredQ;
  logic          relaxedCap, firstQ;
  logic [AW-1:0] lastBase;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeCap  <= '0;
      coveredQ   <= '0;
      relaxedCap <= 1'b0;
      firstQ     <= 1'b1;
      lastBase   <= '0;
    end else if (reqValid && reqReady) begin
      activeCap  <= reqActive;
      coveredQ   <= '0;
      relaxedCap <= reqRelaxed;
      firstQ     <= 1'b1;
    end else if (txnValid && txnReady) begin
      coveredQ   <= coveredQ | txnMask;
      firstQ     <= 1'b0;
      lastBase   <= txnBase;
    end
  end

  AST_MASK_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    txnValid |-> (txnMask != '0)); // R7
  AST_MASK_IN_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    txnValid |-> ((txnMask & ~activeCap) == '0)); // R7
  AST_MASK_DISJOINT: assert property (@(posedge clk) disable iff (!rstN)
    txnValid |-> ((txnMask & coveredQ) == '0)); // R7
  AST_UNION_AT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (coveredQ == activeCap)); // R7
  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rstN)
    (txnValid && !txnReady) |=> (txnValid && $stable(txnBase) && $stable(txnBytes) && $stable(txnMask))); // R8
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    txnValid |-> !reqReady); // R8
  AST_LEN_POW2: assert property (@(posedge clk) disable iff (!rstN)
    txnValid |-> ($countones(txnBytes) == 1)); // R6
  AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    txnValid |-> ((txnBase[SEG_LG:0] & (txnBytes - 1'b1)) == '0)); // R5
  AST_ASCENDING: assert property (@(posedge clk) disable iff (!rstN)
    (txnValid && relaxedCap && !firstQ) |-> (txnBase > lastBase)); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9
endmodule

bind halfwarp_coalescer coal_checker #(.NT(NT), .AW(AW), .SEG_LG(SEG_LG)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqReady  (reqReady),
  .reqRelaxed(reqRelaxed),
  .reqActive (reqActive),
  .txnValid  (txnValid),
  .txnReady  (txnReady),
  .txnBase   (txnBase),
  .txnBytes  (txnBytes),
  .txnMask   (txnMask),
  .done      (done)
);

// File: tb/halfwarp_coalescer_tb_top.sv
module halfwarp_coalescer_tb_top;
  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqReady;
  logic          reqRelaxed = 1'b0;
  logic [2:0]    reqSize = '0;
  logic [15:0]   reqActive = '0;
  logic [511:0]  reqAddr = '0;
  logic          txnValid;
  logic          txnReady = 1'b1;
  logic [31:0]   txnBase;
  logic [7:0]    txnBytes;
  logic [15:0]   txnMask;
  logic          done;

  always #5 clk = ~clk;

  halfwarp_coalescer dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqRelaxed(reqRelaxed), .reqSize(reqSize), .reqActive(reqActive),
    .reqAddr(reqAddr), .txnValid(txnValid), .txnReady(txnReady),
    .txnBase(txnBase), .txnBytes(txnBytes), .txnMask(txnMask), .done(done)
  );

  typedef struct {
    bit          isDone;
    logic [31:0] base;
    logic [7:0]  bytes;
    logic [15:0] mask;
    string       tag;
  } expItem_t;

  expItem_t sbq[$];
  int checks = 0;
  int fails  = 0;
  bit stallMode = 1'b0;
  logic [31:0] laneAddr [16];

  task automatic note(input bit ok, input string tag, input string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s", tag, what);
    end
  endtask

  task automatic expT(input logic [31:0] b, input logic [7:0] n,
                      input logic [15:0] m, input string tag);
    expItem_t it;
    it.isDone = 1'b0; it.base = b; it.bytes = n; it.mask = m; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic expDone(input string tag);
    expItem_t it;
    it.isDone = 1'b1; it.base = '0; it.bytes = '0; it.mask = '0; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic seqAddr(input logic [31:0] start, input int step);
    for (int k = 0; k < 16; k++) laneAddr[k] = start + 32'(k * step);
  endtask

  // expectations must be queued before the call
  task automatic runReq(input bit relaxed, input logic [2:0] size,
                        input logic [15:0] active);
    @(posedge clk); #1;
    reqValid   = 1'b1;
    reqRelaxed = relaxed;
    reqSize    = size;
    reqActive  = active;
    for (int k = 0; k < 16; k++) reqAddr[k*32 +: 32] = laneAddr[k];
    @(posedge clk); #1;
    reqValid = 1'b0;
    wait (sbq.size() == 0);
    @(posedge clk);
  endtask

  // memory-side ready, changed just after each rising edge
  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk); #1;
      cyc++;
      txnReady = stallMode ? (cyc % 3 == 0) : 1'b1;
    end
  end

  // monitor / scoreboard
  initial begin
    bit hsPrev = 0, accPrev = 0, stallPrev = 0;
    logic [31:0] hBase = '0;
    logic [7:0]  hBytes = '0;
    logic [15:0] hMask = '0;
    expItem_t it;
    forever begin
      @(negedge clk);
      if (rstN) begin
        if (stallPrev)
          note(txnValid && txnBase == hBase && txnBytes == hBytes && txnMask == hMask, "R8",
               $sformatf("stalled offer changed: act %h/%0d/%h exp %h/%0d/%h",
                         txnBase, txnBytes, txnMask, hBase, hBytes, hMask));
        if (txnValid && reqReady)
          note(1'b0, "R8", $sformatf("reqReady act %b exp 0 while busy", reqReady));
        if (txnValid && txnReady) begin
          if (sbq.size() == 0 || sbq[0].isDone) begin
            note(1'b0, "R7", $sformatf("unexpected txn act %h/%0d/%h exp none",
                                       txnBase, txnBytes, txnMask));
          end else begin
            it = sbq.pop_front();
            note(txnBase == it.base && txnBytes == it.bytes && txnMask == it.mask, it.tag,
                 $sformatf("txn act %h/%0d/%h exp %h/%0d/%h", txnBase, txnBytes,
                           txnMask, it.base, it.bytes, it.mask));
          end
        end
        if (done) begin
          note(hsPrev || accPrev, "R9", $sformatf("done timing act hs=%b acc=%b exp one set",
                                                  hsPrev, accPrev));
          if (sbq.size() == 0 || !sbq[0].isDone) begin
            note(1'b0, "R9", $sformatf("done act 1 exp 0, %0d items pending", sbq.size()));
          end else begin
            it = sbq.pop_front();
            note(1'b1, it.tag, "done");
          end
        end
      end
      hsPrev    = txnValid && txnReady;
      accPrev   = reqValid && reqReady;
      stallPrev = txnValid && !txnReady;
      hBase = txnBase; hBytes = txnBytes; hMask = txnMask;
    end
  end

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    note(1'b0, "R9", "watchdog expired: act hung exp completion");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    note(reqReady && !txnValid && !done, "R10",
         $sformatf("reset state act rdy=%b v=%b d=%b exp 1/0/0", reqReady, txnValid, done));

    // R1: strict, 4-byte words, sequential aligned
    seqAddr(32'h1000, 4);
    expT(32'h1000, 8'd64, 16'hFFFF, "R1"); expDone("R1");
    runReq(1'b0, 3'd2, 16'hFFFF);

    // R1: strict, 1-byte words, stripe of 16 bytes
    seqAddr(32'h2030, 1);
    expT(32'h2030, 8'd16, 16'hFFFF, "R1"); expDone("R1");
    runReq(1'b0, 3'd0, 16'hFFFF);

    // R3: disabled lanes with wild addresses, lane 0 off
    seqAddr(32'h1000, 4);
    laneAddr[0] = 32'hDEAD0000; laneAddr[3] = 32'hDEAD0001; laneAddr[7] = 32'h0BAD0BAD;
    expT(32'h1000, 8'd64, 16'hFF76, "R3"); expDone("R3");
    runReq(1'b0, 3'd2, 16'hFF76);

    // R2: strict 16-byte words -> two halves
    seqAddr(32'h4000, 16);
    expT(32'h4000, 8'd128, 16'h00FF, "R2");
    expT(32'h4080, 8'd128, 16'hFF00, "R2"); expDone("R2");
    runReq(1'b0, 3'd4, 16'hFFFF);

    // R2: only upper half enabled -> one transaction
    expT(32'h4080, 8'd128, 16'hFF00, "R2"); expDone("R2");
    runReq(1'b0, 3'd4, 16'hFF00);

    // R4: misaligned, with stalls (R8)
    stallMode = 1'b1;
    seqAddr(32'h1004, 4);
    expT(32'h1004, 8'd4, 16'h0001, "R4");
    expT(32'h1008, 8'd4, 16'h0002, "R4");
    expT(32'h100C, 8'd4, 16'h0004, "R4"); expDone("R4");
    runReq(1'b0, 3'd2, 16'h0007);

    // R4: out of order, lane order kept
    seqAddr(32'h1000, 4);
    laneAddr[0] = 32'h1004; laneAddr[1] = 32'h1000;
    expT(32'h1004, 8'd4, 16'h0001, "R4");
    expT(32'h1000, 8'd4, 16'h0002, "R4"); expDone("R4");
    runReq(1'b0, 3'd2, 16'h0003);

    // R5/R6: relaxed, same permuted pattern -> one 64-byte segment
    expT(32'h1000, 8'd64, 16'hFFFF, "R6"); expDone("R6");
    runReq(1'b1, 3'd2, 16'hFFFF);
    stallMode = 1'b0;

    // R6: relaxed, 1-byte words inside one quarter
    seqAddr(32'h2030, 1);
    expT(32'h2020, 8'd32, 16'hFFFF, "R6"); expDone("R6");
    runReq(1'b1, 3'd0, 16'hFFFF);

    // R6: mixed 64 + 32 across two segments
    seqAddr(32'h1050, 4);
    expT(32'h1040, 8'd64, 16'h0FFF, "R6");
    expT(32'h1080, 8'd32, 16'hF000, "R6"); expDone("R6");
    runReq(1'b1, 3'd2, 16'hFFFF);

    // R5: descending lanes issued ascending
    laneAddr[0] = 32'h3000; laneAddr[1] = 32'h2000;
    expT(32'h2000, 8'd32, 16'h0002, "R5");
    expT(32'h3000, 8'd32, 16'h0001, "R5"); expDone("R5");
    runReq(1'b1, 3'd2, 16'h0003);

    // R5: 8-byte words fill a full segment
    seqAddr(32'h5000, 8);
    expT(32'h5000, 8'd128, 16'hFFFF, "R5"); expDone("R5");
    runReq(1'b1, 3'd3, 16'hFFFF);

    // R9: empty request
    expDone("R9");
    runReq(1'b1, 3'd2, 16'h0000);
    expDone("R9");
    runReq(1'b0, 3'd2, 16'h0000);

    repeat (3) @(posedge clk);
    finishRun();
  end
endmodule